// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

The block reads a run of bytes from a four-wire serial EEPROM that is reached through plain control lines: a serial clock, a data line toward the memory, a data line from it, and two access lines that together open and close the memory. A request carries a 16-bit start offset and a byte count. Once a request is taken, the block opens access in two ordered steps. It sends a read command (opcode 0x03) followed by the two offset bytes. It clocks in the requested number of bytes and then closes access in the opposite two-step order.

Every level on the control lines is held for a fixed number of system clock cycles, set by the parameter `DIV`. This sets the serial clock rate. Received bytes leave on a valid/ready stream. When the consumer holds back, the serial clock pauses between bytes and never inside a bit. A one-cycle pulse marks the end of each run.

Top module: `eeprom_read_seq`

## Requirements
- R1: Enabling access takes two steps. `sel_arm` rises first while `sel_inh` stays 1 for `DIV` cycles. After that, `sel_inh` falls to 0. `sel_inh` never falls unless `sel_arm` was already 1 in the previous cycle.
- R2: Disabling access takes two steps. `sel_inh` rises to 1 for `DIV` cycles while `sel_arm` stays 1, and only then does `sel_arm` fall to 0. After reset and between runs, `sel_arm`=0 and `sel_inh`=1.
- R3: The first 24 bits sent on `ser_dout` are the opcode 0x03, then the offset high byte, then the offset low byte. Each byte is sent most significant bit first.
- R4: Each sent bit is a cell of three phases of `DIV` cycles each. In the first phase the bit is driven with `ser_clk` low. In the second phase `ser_clk` is high. In the third phase `ser_clk` is low again. The bit is held through all three phases. `ser_dout` is 0 outside sent-bit cells.
- R5: Each received bit is a cell of two phases of `DIV` cycles. `ser_clk` is high for the first phase, and `ser_din` is sampled in its last cycle. `ser_clk` is low for the second phase. Each byte is built by shifting left, so the first bit received becomes bit 7.
- R6: Exactly `req_count` bytes are read after the header, from consecutive addresses starting at the offset, wrapping modulo 2^16. They appear on `rd_data` in address order. Access is then disabled.
- R7: A count of zero runs the enable, the 24-bit header and the disable, and produces no byte.
- R8: `req_ready` is 1 only while idle. A request is taken on a cycle where `req_valid` and `req_ready` are both 1. `req_valid`, `req_offset` and `req_count` have no effect while a run is in progress.
- R9: `rd_valid` with stable `rd_data` holds until a cycle with `rd_ready`=1. Before each byte there is at least one gate cycle with `ser_clk` low. The byte starts only from a gate cycle in which `rd_valid` is 0 or `rd_ready` is 1.
- R10: `run_done` is a one-cycle pulse in the first idle cycle after the disable phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_offset | input | 16 | Start byte address |
| req_count | input | CNT_W | Number of bytes to read |
| sel_arm | output | 1 | Access line that is set first on enable and cleared last on disable |
| sel_inh | output | 1 | Access line that is 1 while access is closed |
| ser_clk | output | 1 | Serial clock to the memory |
| ser_dout | output | 1 | Serial data to the memory |
| ser_din | input | 1 | Serial data from the memory |
| rd_valid | output | 1 | Received byte present |
| rd_data | output | 8 | Received byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| run_done | output | 1 | End-of-run pulse |

## Verification
The bench builds the block with `DIV`=2 and `CNT_W`=4. The short phases keep every bit cell only a few cycles long, so many full runs fit in a short test. The 4-bit count makes the largest run of 15 bytes reachable, next to a zero-count run. A start offset of 0xFFF8 then carries the address across the 16-bit wrap. Randomised and long-held consumer stalls land on the gate cycle before each byte, and one run starts while the previous run's last byte is still unaccepted.

// File: rtl/eeprom_read_seq.sv
module eeprom_read_seq #(
  parameter int DIV   = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_offset,
  input  logic [CNT_W-1:0] req_count,
  output logic             sel_arm,
  output logic             sel_inh,
  output logic             ser_clk,
  output logic             ser_dout,
  input  logic             ser_din,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             run_done
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);
  localparam logic [7:0] OP_READ = 8'h03;

  typedef enum logic [3:0] {
    S_IDLE, S_EN_ARM, S_EN_INH, S_TX_SET, S_TX_HI, S_TX_LO,
    S_GATE, S_RX_HI, S_RX_LO, S_DIS
  } st_t;

  st_t             st;
  logic [PW-1:0]   pc;
  logic [23:0]     tx_sh;
  logic [4:0]      tx_n;
  logic [2:0]      rx_n;
  logic [7:0]      rx_sh;
  logic [CNT_W-1:0] rem;
  logic            pe;

  assign pe        = (pc == PLAST);
  assign req_ready = (st == S_IDLE);
  assign sel_arm   = (st != S_IDLE);
  assign sel_inh   = (st == S_IDLE) || (st == S_EN_ARM) || (st == S_DIS);
  assign ser_clk   = (st == S_TX_HI) || (st == S_RX_HI);
  assign ser_dout  = ((st == S_TX_SET) || (st == S_TX_HI) || (st == S_TX_LO)) && tx_sh[23];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc       <= '0;
      tx_sh    <= '0;
      tx_n     <= '0;
      rx_n     <= '0;
      rx_sh    <= '0;
      rem      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      run_done <= 1'b0;
    end else begin
      run_done <= 1'b0;
      if (st == S_IDLE || st == S_GATE || pe) pc <= '0;
      else pc <= pc + 1'b1;
      if (rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st    <= S_EN_ARM;
          tx_sh <= {OP_READ, req_offset};
          rem   <= req_count;
        end
        S_EN_ARM: if (pe) st <= S_EN_INH;
        S_EN_INH: if (pe) begin
          st   <= S_TX_SET;
          tx_n <= '0;
        end
        S_TX_SET: if (pe) st <= S_TX_HI;
        S_TX_HI:  if (pe) st <= S_TX_LO;
        S_TX_LO: if (pe) begin
          tx_sh <= {tx_sh[22:0], 1'b0};
          if (tx_n == 5'd23) st <= (rem == '0) ? S_DIS : S_GATE;
          else begin
            tx_n <= tx_n + 1'b1;
            st   <= S_TX_SET;
          end
        end
        S_GATE: if (!rd_valid || rd_ready) begin
          st   <= S_RX_HI;
          rx_n <= '0;
        end
        S_RX_HI: if (pe) begin
          rx_sh <= {rx_sh[6:0], ser_din};
          st    <= S_RX_LO;
        end
        S_RX_LO: if (pe) begin
          if (rx_n == 3'd7) begin
            rd_data  <= rx_sh;
            rd_valid <= 1'b1;
            rem      <= rem - 1'b1;
            st       <= (rem == CNT_W'(1)) ? S_DIS : S_GATE;
          end else begin
            rx_n <= rx_n + 1'b1;
            st   <= S_RX_HI;
          end
        end
        S_DIS: if (pe) begin
          st       <= S_IDLE;
          run_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_read_seq_chk.sv
module eeprom_read_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       sel_arm,
  input logic       sel_inh,
  input logic       ser_clk,
  input logic       ser_dout,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_ready,
  input logic       run_done
);
  a_r1_inh_falls_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_inh) |-> (sel_arm && $past(sel_arm)));

  a_r2_arm_falls_after_inh: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_arm) |-> (sel_inh && $past(sel_inh)));

  a_r4_quiet_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    sel_inh |-> (!ser_clk && !ser_dout));

  a_r8_accept_starts_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && sel_arm && sel_inh));

  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> (req_ready && !sel_arm && $past(sel_arm)));
endmodule

bind eeprom_read_seq eeprom_read_seq_chk u_chk (.*);

// File: tb/eeprom_read_seq_bench.sv
module eeprom_read_seq_bench;
  localparam int DIV = 2;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [15:0] req_offset;
  logic [CNT_W-1:0] req_count;
  logic sel_arm, sel_inh, ser_clk, ser_dout;
  logic ser_din = 1'b0;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic run_done;

  always #4 clk = ~clk;

  eeprom_read_seq #(.DIV(DIV), .CNT_W(CNT_W)) u_eeprom_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_count(req_count), .sel_arm(sel_arm),
    .sel_inh(sel_inh), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .run_done(run_done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rdy_mode = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom(input logic [15:0] a);
    return 8'(a * 29 + (a >> 8) * 7 + 16'h5A);
  endfunction

  // memory model on the serial pins
  int ee_bits = 0;
  logic [23:0] ee_cmd = '0;
  logic [15:0] ee_off = '0;
  int ee_exp = 0;
  bit ee_live = 0;

  always @(posedge ser_clk) if (sel_arm && !sel_inh) begin
    if (ee_bits < 24) ee_cmd = {ee_cmd[22:0], ser_dout};
    ee_bits++;
    if (ee_bits == 24) begin
      chk(ee_cmd[23:16] == 8'h03, "R3 opcode", ee_cmd[23:16], 3);
      chk(ee_cmd[15:0] == ee_off, "R3 address", ee_cmd[15:0], ee_off);
    end
  end

  always @(negedge ser_clk) if (sel_arm && !sel_inh && ee_bits >= 24) begin
    automatic int k = ee_bits - 24;
    automatic logic [7:0] b = rom(ee_cmd[15:0] + 16'(k / 8));
    ser_din = b[7 - (k % 8)];
  end

  always @(posedge sel_inh) if (ee_live) begin
    chk(ee_bits == 24 + 8 * ee_exp, "R6/R7 serial bit count", ee_bits, 24 + 8 * ee_exp);
    ee_live = 0;
    ee_bits = 0;
  end

  // cycle reference model
  typedef struct packed {
    logic [1:0] kind;  // 0 plain, 1 byte end, 2 gate, 3 last
    logic arm, inh, sck, dout;
  } ph_t;

  ph_t q[$];
  ph_t m_cur;
  bit m_busy = 0, m_mv = 0, m_done = 0;
  logic [7:0] m_md = '0;
  int m_left = 0, m_j = 0;
  logic [15:0] m_off = '0;

  always @(posedge clk) begin
    automatic bit old_mv = m_mv;
    if (!rst_n) begin
      m_busy = 0; m_mv = 0; m_done = 0; m_md = '0; q.delete();
    end else begin
      if (m_mv && rd_ready) m_mv = 0;
      m_done = 0;
      if (!m_busy) begin
        if (req_valid) begin
          automatic logic [23:0] hdr = {8'h03, req_offset};
          m_off = req_offset;
          m_j = 0;
          q.push_back('{2'd0, 1'b1, 1'b1, 1'b0, 1'b0});
          q.push_back('{2'd0, 1'b1, 1'b0, 1'b0, 1'b0});
          for (int i = 23; i >= 0; i--) begin
            q.push_back('{2'd0, 1'b1, 1'b0, 1'b0, hdr[i]});
            q.push_back('{2'd0, 1'b1, 1'b0, 1'b1, hdr[i]});
            q.push_back('{2'd0, 1'b1, 1'b0, 1'b0, hdr[i]});
          end
          for (int j = 0; j < int'(req_count); j++) begin
            q.push_back('{2'd2, 1'b1, 1'b0, 1'b0, 1'b0});
            for (int k = 0; k < 8; k++) begin
              q.push_back('{2'd0, 1'b1, 1'b0, 1'b1, 1'b0});
              q.push_back('{(k == 7) ? 2'd1 : 2'd0, 1'b1, 1'b0, 1'b0, 1'b0});
            end
          end
          q.push_back('{2'd3, 1'b1, 1'b1, 1'b0, 1'b0});
          m_cur = q.pop_front();
          m_left = DIV;
          m_busy = 1;
        end
      end else if (m_cur.kind == 2'd2) begin
        if (!old_mv || rd_ready) begin
          m_cur = q.pop_front();
          m_left = DIV;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_cur.kind == 2'd1) begin
            m_mv = 1;
            m_md = rom(m_off + 16'(m_j));
            m_j++;
          end
          if (m_cur.kind == 2'd3) begin
            m_done = 1;
            m_busy = 0;
          end else begin
            m_cur = q.pop_front();
            m_left = DIV;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic logic e_arm = m_busy ? m_cur.arm : 1'b0;
    automatic logic e_inh = m_busy ? m_cur.inh : 1'b1;
    automatic logic e_sck = m_busy ? m_cur.sck : 1'b0;
    automatic logic e_do  = m_busy ? m_cur.dout : 1'b0;
    chk(sel_arm === e_arm, "R1/R2 sel_arm", sel_arm, e_arm);
    chk(sel_inh === e_inh, "R1/R2 sel_inh", sel_inh, e_inh);
    chk(ser_clk === e_sck, "R4/R5 ser_clk", ser_clk, e_sck);
    chk(ser_dout === e_do, "R3/R4 ser_dout", ser_dout, e_do);
    chk(req_ready === !m_busy, "R8 req_ready", req_ready, !m_busy);
    chk(rd_valid === m_mv, "R9 rd_valid", rd_valid, m_mv);
    if (m_mv) chk(rd_data === m_md, "R5/R6 rd_data", rd_data, m_md);
    chk(run_done === m_done, "R10 run_done", run_done, m_done);
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: rd_ready = 1'b1;
      1: rd_ready = ($urandom % 3) != 0;
      default: rd_ready = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic launch(input logic [15:0] o, input int c, input bit hold);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_offset = o;
    req_count = CNT_W'(c);
    ee_off = o;
    ee_exp = c;
    ee_live = 1;
    @(negedge clk);
    if (hold) begin
      // R8: changed request fields during a run must be ignored
      req_offset = 16'hBEEF;
      req_count = CNT_W'(9);
      repeat (30) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!run_done) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_offset = '0;
    req_count = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_inh === 1'b1 && sel_arm === 1'b0, "R2 reset access state", {sel_arm, sel_inh}, 2'b01);
    chk(req_ready === 1'b1 && rd_valid === 1'b0, "R8 reset idle", {req_ready, rd_valid}, 2'b10);

    launch(16'h1234, 3, 0);  wait_done();   // R6 basic run
    launch(16'hA5C3, 0, 0);  wait_done();   // R7 zero count
    rdy_mode = 1;
    launch(16'hFFF8, 15, 0); wait_done();   // R6 max count, address wrap
    rdy_mode = 2;
    launch(16'h0040, 4, 0);                 // R9 long stall
    while (!rd_valid) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(ser_clk === 1'b0, "R9 clock held during stall", ser_clk, 0);
    rdy_mode = 0;
    wait_done();
    rdy_mode = 1;
    launch(16'h0100, 2, 1);  wait_done();   // R8 busy request ignored
    rdy_mode = 2;
    launch(16'h7F01, 1, 0);  wait_done();   // last byte left pending
    rdy_mode = 1;
    launch(16'h0002, 2, 0);  wait_done();   // R9 new run while byte pending
    rdy_mode = 0;
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule